// File: doc/BRIEF.md
# Branch and Next-PC Sequencing Unit

This block works out where a 32-bit processor fetches next after each issued instruction, and which side effects that instruction has on the way. Its inputs are the current PC, the operand register A and a pre-selected target value. The target is a register operand or an already sign-extended immediate, and the decode stage chooses which. A decoded branch kind and a set of modifier bits complete the inputs. From these the unit produces the next PC, a taken flag, a delay-slot flag, a link write with its value, and single-cycle strobes that set or clear the break-in-progress status bit and set the interrupt-enable bit.

The unit supports conditional branches that compare A with zero as a signed number, relative and absolute unconditional jumps with optional linking, a break jump, and three return flavours whose target is A plus the immediate. The delay forms let the instruction that follows run before the redirect. A two-state sequencer keeps this ordering. In state SEQ (sequential) each issued instruction is decoded normally. When a delay form issues, the unit takes the transition ENTER_SLOT into state SLOT. There it holds the resolved destination and whether the branch was taken. The next issued instruction is the delay-slot instruction, and it takes the transition LEAVE_SLOT back to SEQ. Its next PC is the held destination, and any branch kind it carries is ignored. A cycle with no issued instruction takes neither transition.

Top module: `branch_unit`

## Requirements
- R1: After reset the sequencer is in state SEQ (`in_slot` = 0), so the first issued instruction is decoded normally.
- R2: For `op_kind` = 2 (conditional), `cond_sel` selects a signed test of `opnd_a` against zero: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. Codes 6 and 7 are never taken.
- R3: A conditional branch that is taken and has no delay slot gives `next_pc` = `cur_pc` + `target`. When it is not taken it gives `cur_pc` + 4. All PC sums wrap modulo 2^32.
- R4: For `op_kind` = 1 (jump), `taken` = 1 and the destination is `target` when `abs_mode` = 1, or `cur_pc` + `target` when `abs_mode` = 0. With `link_en` = 1, `link_wr` = 1 and `link_val` = `cur_pc`.
- R5: For `op_kind` = 4 (break), `next_pc` = `target`, `taken` = 1, `link_wr` = 1 with `link_val` = `cur_pc`, `brk_set` = 1 and `delay_slot` = 0, whatever `delay_en` holds.
- R6: For `op_kind` = 3 (return), the destination is `opnd_a` + `target` and `delay_slot` is always 1. `ret_kind` = 1 pulses `ie_set`, and `ret_kind` = 2 pulses `brk_clr`.
- R7: A jump or conditional with `delay_en` = 1, and every return, gives `delay_slot` = 1 whether or not the branch is taken, together with `next_pc` = `cur_pc` + 4. The sequencer then enters SLOT on the next clock edge.
- R8: In SLOT, an issued instruction gets `next_pc` equal to the held destination if the branch was taken, or `cur_pc` + 4 if it was not. Its own branch kind is ignored: `taken`, `link_wr`, `delay_slot` and all strobes stay 0. The sequencer returns to SEQ.
- R9: With `issue` = 0, `taken`, `delay_slot`, `link_wr` and all strobes are 0 and the sequencer state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is issued this cycle |
| op_kind | input | 3 | 0 none, 1 jump, 2 conditional, 3 return, 4 break |
| cond_sel | input | 3 | Zero-test selector for conditionals |
| abs_mode | input | 1 | Jump destination is absolute |
| link_en | input | 1 | Jump writes the current PC to the link register |
| delay_en | input | 1 | Jump or conditional has a delay slot |
| ret_kind | input | 2 | 0 plain, 1 interrupt return, 2 break return |
| cur_pc | input | 32 | PC of the issued instruction |
| opnd_a | input | 32 | Register A value |
| target | input | 32 | Register or sign-extended immediate target |
| next_pc | output | 32 | Address of the next instruction to execute |
| taken | output | 1 | Branch taken |
| delay_slot | output | 1 | Instruction is a delay form |
| link_wr | output | 1 | Write `link_val` to the destination register |
| link_val | output | 32 | Link value (current PC) |
| brk_set | output | 1 | Set break-in-progress |
| brk_clr | output | 1 | Clear break-in-progress |
| ie_set | output | 1 | Set interrupt enable |
| in_slot | output | 1 | Sequencer is in SLOT |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and a 4-byte instruction step. With these values, the wrap of a relative jump past address 0xFFFFFFFC and the signed boundary at 0x80000000 are both reachable with literal operands. Those operands sit in the vector table next to the six zero tests. The directed part walks both sequencer transitions, a stall inside SLOT, a branch placed in a delay slot, and a reset taken while in SLOT.

// File: rtl/bru_pkg.sv
package bru_pkg;
    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_JUMP  = 3'd1,
        K_COND  = 3'd2,
        K_RET   = 3'd3,
        K_BREAK = 3'd4
    } kind_e;

    typedef enum logic {
        ST_SEQ  = 1'b0,
        ST_SLOT = 1'b1
    } seq_state_e;

    localparam logic [2:0] CZ_EQ = 3'd0;
    localparam logic [2:0] CZ_NE = 3'd1;
    localparam logic [2:0] CZ_LT = 3'd2;
    localparam logic [2:0] CZ_LE = 3'd3;
    localparam logic [2:0] CZ_GT = 3'd4;
    localparam logic [2:0] CZ_GE = 3'd5;

    localparam logic [1:0] RK_PLAIN = 2'd0;
    localparam logic [1:0] RK_INTR  = 2'd1;
    localparam logic [1:0] RK_BRK   = 2'd2;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_val,
    input  logic [2:0]      sel,
    output logic            hit
);
    import bru_pkg::*;

    logic is_zero;
    logic is_neg;

    assign is_zero = (a_val == '0);
    assign is_neg  = a_val[XLEN-1];

    always_comb begin
        case (sel)
            CZ_EQ:   hit = is_zero;
            CZ_NE:   hit = !is_zero;
            CZ_LT:   hit = is_neg;
            CZ_LE:   hit = is_neg || is_zero;
            CZ_GT:   hit = !is_neg && !is_zero;
            CZ_GE:   hit = !is_neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
    parameter int XLEN = 32
) (
    input  bru_pkg::kind_e  kind,
    input  logic            abs_mode,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] tgt,
    output logic [XLEN-1:0] dest
);
    import bru_pkg::*;

    logic [XLEN-1:0] rel_sum;
    logic [XLEN-1:0] ret_sum;

    assign rel_sum = pc + tgt;
    assign ret_sum = a_val + tgt;

    always_comb begin
        case (kind)
            K_RET:   dest = ret_sum;
            K_BREAK: dest = tgt;
            K_JUMP:  dest = abs_mode ? tgt : rel_sum;
            default: dest = rel_sum;
        endcase
    end
endmodule

// File: rtl/bru_slot_fsm.sv
module bru_slot_fsm #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic            leave,
    input  logic            enter_taken,
    input  logic [XLEN-1:0] enter_dest,
    output logic            in_slot,
    output logic            pend_taken,
    output logic [XLEN-1:0] pend_dest
);
    import bru_pkg::*;

    seq_state_e      state_q, state_d;
    logic            taken_q;
    logic [XLEN-1:0] dest_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:  if (enter) state_d = ST_SLOT;
            ST_SLOT: if (leave) state_d = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            taken_q <= 1'b0;
            dest_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SEQ && enter) begin
                taken_q <= enter_taken;
                dest_q  <= enter_dest;
            end
        end
    end

    assign in_slot    = (state_q == ST_SLOT);
    assign pend_taken = taken_q;
    assign pend_dest  = dest_q;

    assert_slot_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_slot && enter) |=> in_slot);
    assert_slot_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && leave) |=> !in_slot);
    assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enter && !leave) |=> $stable(in_slot));
endmodule

// File: rtl/branch_unit.sv
module branch_unit #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [2:0]      op_kind,
    input  logic [2:0]      cond_sel,
    input  logic            abs_mode,
    input  logic            link_en,
    input  logic            delay_en,
    input  logic [1:0]      ret_kind,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic            delay_slot,
    output logic            link_wr,
    output logic [XLEN-1:0] link_val,
    output logic            brk_set,
    output logic            brk_clr,
    output logic            ie_set,
    output logic            in_slot
);
    import bru_pkg::*;

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    kind_e           kind;
    logic            cond_hit;
    logic [XLEN-1:0] dest;
    logic [XLEN-1:0] seq_pc;
    logic            pend_taken;
    logic [XLEN-1:0] pend_dest;
    logic            enter_slot;
    logic            leave_slot;
    logic            br_hit;

    assign kind   = kind_e'(op_kind);
    assign seq_pc = cur_pc + STEP;

    bru_cond_eval #(.XLEN(XLEN)) u_cond (
        .a_val (opnd_a),
        .sel   (cond_sel),
        .hit   (cond_hit)
    );

    bru_target_calc #(.XLEN(XLEN)) u_tgt (
        .kind     (kind),
        .abs_mode (abs_mode),
        .pc       (cur_pc),
        .a_val    (opnd_a),
        .tgt      (target),
        .dest     (dest)
    );

    bru_slot_fsm #(.XLEN(XLEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter       (enter_slot),
        .leave       (leave_slot),
        .enter_taken (br_hit),
        .enter_dest  (dest),
        .in_slot     (in_slot),
        .pend_taken  (pend_taken),
        .pend_dest   (pend_dest)
    );

    assign enter_slot = issue && !in_slot && delay_slot;
    assign leave_slot = issue && in_slot;

    always_comb begin
        next_pc    = seq_pc;
        taken      = 1'b0;
        delay_slot = 1'b0;
        link_wr    = 1'b0;
        link_val   = cur_pc;
        brk_set    = 1'b0;
        brk_clr    = 1'b0;
        ie_set     = 1'b0;
        br_hit     = 1'b0;
        if (issue && in_slot) begin
            next_pc = pend_taken ? pend_dest : seq_pc;
        end else if (issue) begin
            case (kind)
                K_JUMP: begin
                    br_hit     = 1'b1;
                    link_wr    = link_en;
                    delay_slot = delay_en;
                end
                K_COND: begin
                    br_hit     = cond_hit;
                    delay_slot = delay_en;
                end
                K_RET: begin
                    br_hit     = 1'b1;
                    delay_slot = 1'b1;
                    ie_set     = (ret_kind == RK_INTR);
                    brk_clr    = (ret_kind == RK_BRK);
                end
                K_BREAK: begin
                    br_hit  = 1'b1;
                    link_wr = 1'b1;
                    brk_set = 1'b1;
                end
                default: br_hit = 1'b0;
            endcase
            taken = br_hit;
            if (br_hit && !delay_slot) next_pc = dest;
        end
    end

    assert_one_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({brk_set, brk_clr, ie_set}));
    assert_break_nodelay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_set |-> (!delay_slot && link_wr && taken));
    assert_ret_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_set || brk_clr) |-> (delay_slot && taken));
    assert_delay_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        delay_slot |-> (next_pc == cur_pc + STEP));
    assert_slot_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot |-> (!taken && !link_wr && !delay_slot && !brk_set));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |-> (!taken && !link_wr && !delay_slot && !ie_set && !brk_clr));
endmodule

// File: tb/branch_unit_tb.sv
module branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [2:0]  cond_sel = '0;
    logic        abs_mode = 1'b0;
    logic        link_en = 1'b0;
    logic        delay_en = 1'b0;
    logic [1:0]  ret_kind = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] target = '0;
    logic [31:0] next_pc;
    logic        taken, delay_slot, link_wr, brk_set, brk_clr, ie_set, in_slot;
    logic [31:0] link_val;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_kind(op_kind),
        .cond_sel(cond_sel), .abs_mode(abs_mode), .link_en(link_en),
        .delay_en(delay_en), .ret_kind(ret_kind), .cur_pc(cur_pc),
        .opnd_a(opnd_a), .target(target), .next_pc(next_pc), .taken(taken),
        .delay_slot(delay_slot), .link_wr(link_wr), .link_val(link_val),
        .brk_set(brk_set), .brk_clr(brk_clr), .ie_set(ie_set), .in_slot(in_slot)
    );

    // {kind, cond, abs, link, dly, rk, pc, a, tgt, exp_next, exp_taken, exp_dly}
    localparam int NV = 16;
    localparam logic [140:0] VEC [NV] = '{
        {3'd2, 3'd0, 3'b000, 2'd0, 32'h100, 32'h0,        32'h40,       32'h140,  1'b1, 1'b0},
        {3'd2, 3'd0, 3'b000, 2'd0, 32'h100, 32'h5,        32'h40,       32'h104,  1'b0, 1'b0},
        {3'd2, 3'd1, 3'b000, 2'd0, 32'h100, 32'h5,        32'h40,       32'h140,  1'b1, 1'b0},
        {3'd2, 3'd2, 3'b000, 2'd0, 32'h100, 32'hFFFFFFFF, 32'h40,       32'h140,  1'b1, 1'b0},
        {3'd2, 3'd2, 3'b000, 2'd0, 32'h100, 32'h0,        32'h40,       32'h104,  1'b0, 1'b0},
        {3'd2, 3'd3, 3'b000, 2'd0, 32'h100, 32'h0,        32'h40,       32'h140,  1'b1, 1'b0},
        {3'd2, 3'd3, 3'b000, 2'd0, 32'h100, 32'h1,        32'h40,       32'h104,  1'b0, 1'b0},
        {3'd2, 3'd4, 3'b000, 2'd0, 32'h100, 32'h1,        32'h40,       32'h140,  1'b1, 1'b0},
        {3'd2, 3'd4, 3'b000, 2'd0, 32'h100, 32'h80000000, 32'h40,       32'h104,  1'b0, 1'b0},
        {3'd2, 3'd5, 3'b000, 2'd0, 32'h100, 32'h0,        32'h40,       32'h140,  1'b1, 1'b0},
        {3'd2, 3'd5, 3'b000, 2'd0, 32'h100, 32'h80000000, 32'h40,       32'h104,  1'b0, 1'b0},
        {3'd2, 3'd0, 3'b000, 2'd0, 32'h100, 32'h0,        32'hFFFFFFF0, 32'hF0,   1'b1, 1'b0},
        {3'd1, 3'd0, 3'b000, 2'd0, 32'hFFFFFFFC, 32'h0,   32'h8,        32'h4,    1'b1, 1'b0},
        {3'd1, 3'd0, 3'b100, 2'd0, 32'h100, 32'h0,        32'h2000,     32'h2000, 1'b1, 1'b0},
        {3'd0, 3'd0, 3'b000, 2'd0, 32'h1000, 32'h0,       32'h0,        32'h1004, 1'b0, 1'b0},
        {3'd4, 3'd0, 3'b001, 2'd0, 32'h300, 32'h0,        32'h18,       32'h18,   1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [2:0] c, input logic ab,
                         input logic lk, input logic dl, input logic [1:0] rk,
                         input logic [31:0] pc, input logic [31:0] a, input logic [31:0] t);
        @(negedge clk);
        issue = 1'b1; op_kind = k; cond_sel = c; abs_mode = ab; link_en = lk;
        delay_en = dl; ret_kind = rk; cur_pc = pc; opnd_a = a; target = t;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        issue = 1'b0; op_kind = 3'd0;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "in_slot after reset", 32'(in_slot), 32'd0);
        chk("R9", "taken idle", 32'(taken), 32'd0);

        // R2 R3 R4 R5 via table
        for (int i = 0; i < NV; i++) begin
            logic [140:0] v;
            v = VEC[i];
            drive(v[140:138], v[137:135], v[134], v[133], v[132], v[131:130],
                  v[129:98], v[97:66], v[65:34]);
            chk("R2/R3 vec", "next_pc", next_pc, v[33:2]);
            chk("R2/R3 vec", "taken", 32'(taken), 32'(v[1]));
            chk("R7 vec", "delay_slot", 32'(delay_slot), 32'(v[0]));
        end

        // R2 undefined condition codes
        drive(3'd2, 3'd6, 0, 0, 0, 2'd0, 32'h100, 32'h0, 32'h40);
        chk("R2", "code 6 taken", 32'(taken), 32'd0);
        drive(3'd2, 3'd7, 0, 0, 0, 2'd0, 32'h100, 32'h5, 32'h40);
        chk("R2", "code 7 next", next_pc, 32'h104);

        // R4 link on absolute jump
        drive(3'd1, 3'd0, 1, 1, 0, 2'd0, 32'h500, 32'h0, 32'h900);
        chk("R4", "link_wr", 32'(link_wr), 32'd1);
        chk("R4", "link_val", link_val, 32'h500);
        drive(3'd1, 3'd0, 0, 0, 0, 2'd0, 32'h500, 32'h0, 32'h10);
        chk("R4", "no link", 32'(link_wr), 32'd0);

        // R5 break ignores delay_en
        drive(3'd4, 3'd0, 0, 0, 1, 2'd0, 32'h600, 32'h0, 32'h20);
        chk("R5", "brk_set", 32'(brk_set), 32'd1);
        chk("R5", "link_val", link_val, 32'h600);
        chk("R5", "delay_slot", 32'(delay_slot), 32'd0);
        chk("R5", "next_pc", next_pc, 32'h20);
        idle();
        chk("R5", "no slot after break", 32'(in_slot), 32'd0);

        // R7 R8 delayed relative jump
        drive(3'd1, 3'd0, 0, 0, 1, 2'd0, 32'h200, 32'h0, 32'h80);
        chk("R7", "taken", 32'(taken), 32'd1);
        chk("R7", "delay_slot", 32'(delay_slot), 32'd1);
        chk("R7", "next_pc", next_pc, 32'h204);
        idle();
        chk("R7", "in_slot", 32'(in_slot), 32'd1);
        chk("R9", "stall keeps slot", 32'(in_slot), 32'd1);
        drive(3'd4, 3'd0, 0, 0, 0, 2'd0, 32'h204, 32'h0, 32'h44);
        chk("R8", "slot next_pc", next_pc, 32'h280);
        chk("R8", "slot break ignored brk_set", 32'(brk_set), 32'd0);
        chk("R8", "slot break ignored link", 32'(link_wr), 32'd0);
        chk("R8", "slot taken", 32'(taken), 32'd0);
        idle();
        chk("R8", "back to seq", 32'(in_slot), 32'd0);

        // R7 delayed conditional not taken
        drive(3'd2, 3'd0, 0, 0, 1, 2'd0, 32'h300, 32'h1, 32'h80);
        chk("R7", "nt delay_slot", 32'(delay_slot), 32'd1);
        chk("R7", "nt taken", 32'(taken), 32'd0);
        drive(3'd0, 3'd0, 0, 0, 0, 2'd0, 32'h304, 32'h0, 32'h0);
        chk("R8", "nt slot next", next_pc, 32'h308);

        // R6 interrupt return
        drive(3'd3, 3'd0, 0, 0, 0, 2'd1, 32'h700, 32'h1000, 32'h8);
        chk("R6", "ie_set", 32'(ie_set), 32'd1);
        chk("R6", "delay_slot", 32'(delay_slot), 32'd1);
        chk("R6", "brk_clr", 32'(brk_clr), 32'd0);
        drive(3'd0, 3'd0, 0, 0, 0, 2'd0, 32'h704, 32'h0, 32'h0);
        chk("R6", "ret dest", next_pc, 32'h1008);

        // R6 break return
        drive(3'd3, 3'd0, 0, 0, 0, 2'd2, 32'h800, 32'h2000, 32'hFFFFFFFC);
        chk("R6", "brk_clr", 32'(brk_clr), 32'd1);
        chk("R6", "ie_set", 32'(ie_set), 32'd0);
        drive(3'd0, 3'd0, 0, 0, 0, 2'd0, 32'h804, 32'h0, 32'h0);
        chk("R6", "brk ret dest", next_pc, 32'h1FFC);

        // R1 reset in slot
        drive(3'd1, 3'd0, 1, 0, 1, 2'd0, 32'h900, 32'h0, 32'h40);
        @(negedge clk);
        issue = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "reset clears slot", 32'(in_slot), 32'd0);
        drive(3'd0, 3'd0, 0, 0, 0, 2'd0, 32'h904, 32'h0, 32'h0);
        chk("R1", "seq after reset", next_pc, 32'h908);

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule